// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. It is clocked by the test clock only and has no dedicated test-reset pin. The chip's power-on reset brings it into its idle reset state, and five rising clock edges with the mode input held high bring it back there from any other state. A sixteen-state controller follows the mode input. It moves a 3-bit instruction register, or one of three data registers, between the serial input and the serial output: a one-bit bypass cell, a 32-bit identification word, or a boundary register whose length is a parameter.

The current instruction selects the data register and drives the controls that go to the pin ring. One control forces the functional outputs to high impedance. One lets the boundary register drive the pins. A strobe marks the cycle in which the ring is sampled. The boundary register also has an update stage that holds the last value shifted in. The lowest `PIN_CNT` boundary cells are tied to pins. The cells above them are placeholders.

All interfaces are plain serial or level signals. There is no valid/ready handshake, because the test clock paces every transfer and nothing can stall it.

Top module: `bscan_tap_ctrl`

## Requirements
- R1: At power-on reset the controller is in its reset state. Five consecutive rising edges of `tck` with `tms` high return it to that state from any state.
- R2: `tms` and `tdi` are sampled on rising `tck` edges. `tdo` and `tdo_oe` change only on falling `tck` edges.
- R3: A newly shifted instruction takes effect only when the controller passes the update-instruction state. Until then the outputs that depend on the instruction keep their values.
- R4: In the reset state the instruction becomes 001, which selects identification. The 32-bit identification word `ID_CODE` is loaded in capture-data and shifted out bit 0 first.
- R5: In capture-instruction the instruction shift register loads binary 001: bit 0 is 1, bits 1 and 2 are 0. These bits are shifted out bit 0 first.
- R6: Instruction 111 selects the bypass cell. The cell captures 0, so a data scan returns 0 followed by the serial input delayed by one cycle.
- R7: The reserved codes 011 and 110 and the private code 101 behave exactly like 111.
- R8: `tdo_oe` is high only while the controller is in shift-data or shift-instruction. Outside those states it is low.
- R9: Codes 000, 010 and 100 select the boundary register. In capture-data, cells 0 to `PIN_CNT`-1 load `pin_sample`, the remaining cells load 1, and `ring_capture` is high for that one cycle.
- R10: Update-data with the boundary register selected copies cells 0 to `PIN_CNT`-1 to `ring_data`. At all other times `ring_data` holds its value. `ring_drive` is high while code 000 is current.
- R11: `force_hiz` is high exactly while code 010 is the current instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Chip power-on reset, active low |
| tms | input | 1 | Mode select, steers the controller |
| tdi | input | 1 | Serial data in |
| pin_sample | input | PIN_CNT | Parallel sample of the pin ring |
| tdo | output | 1 | Serial data out, updated on falling edges |
| tdo_oe | output | 1 | Serial output enable |
| force_hiz | output | 1 | Forces functional outputs to high impedance |
| ring_capture | output | 1 | High in the cycle the pin ring is captured |
| ring_drive | output | 1 | Boundary update stage drives the pins |
| ring_data | output | PIN_CNT | Boundary update stage |

## Verification
Identification scans after power-up and after the five-ones return tell the reset paths apart from the instruction path. Bypass scans with an irregular serial pattern under 111, 011, 101 and 110 show the one-cycle delay and the leading 0, and expose any aliased code that fails to alias. Boundary scans under 100, 010 and 000 use different pin patterns and shift-in values. They separate pin cells from placeholder cells, show that the update stage is loaded, and show which code raises the high-impedance force or pin drive. The force output is also read between shifting and update, to confirm that a new instruction does not take effect early.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR,
    S_UPD_DR, S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_state_t;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_BND} dr_sel_t;

  localparam int unsigned IR_W = 3;
  localparam logic [IR_W-1:0] OP_EXT   = 3'b000;
  localparam logic [IR_W-1:0] OP_ID    = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPZ = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMP  = 3'b100;

  function automatic dr_sel_t decode_sel(input logic [IR_W-1:0] op);
    dr_sel_t s;
    case (op)
      OP_EXT, OP_SAMPZ, OP_SAMP: s = SEL_BND;
      OP_ID:                     s = SEL_ID;
      default:                   s = SEL_BYP;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import scan_pkg::*;
(
  input  logic       tck,
  input  logic       por_n,
  input  logic       tms,
  output tap_state_t st
);

  tap_state_t nxt;

  always_comb begin
    case (st)
      S_TLR:    nxt = tms ? S_TLR    : S_RTI;
      S_RTI:    nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: nxt = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: nxt = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  nxt = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: nxt = tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: nxt = tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: nxt = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: nxt = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: nxt = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  nxt = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: nxt = tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: nxt = tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: nxt = tms ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: nxt = tms ? S_SEL_DR : S_RTI;
      default:  nxt = S_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) st <= S_TLR;
    else        st <= nxt;
  end

  // counts consecutive rising edges with tms high, saturating at five
  logic [2:0] ones_q;
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)              ones_q <= '0;
    else if (!tms)           ones_q <= '0;
    else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;
  end

  a_r1_five_ones_reset: assert property (@(posedge tck) disable iff (!por_n)
    (ones_q == 3'd5) |-> (st == S_TLR));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import scan_pkg::*;
(
  input  logic            tck,
  input  logic            por_n,
  input  tap_state_t      st,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_so
);

  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      ir_sr <= '0;
      ir_q  <= OP_ID;
    end else begin
      case (st)
        S_CAP_IR: ir_sr <= {{(IR_W-2){1'b0}}, 2'b01};
        S_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        default:  ir_sr <= ir_sr;
      endcase
      if (st == S_TLR)         ir_q <= OP_ID;
      else if (st == S_UPD_IR) ir_q <= ir_sr;
    end
  end

  assign ir_so = ir_sr[0];

  a_r3_ir_only_on_update: assert property (@(posedge tck) disable iff (!por_n)
    (st != S_UPD_IR && st != S_TLR) |=> $stable(ir_q));

  a_r5_capture_pattern: assert property (@(posedge tck) disable iff (!por_n)
    (st == S_CAP_IR) |=> (ir_sr[1:0] == 2'b01));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import scan_pkg::*;
#(
  parameter logic [31:0] ID_CODE = 32'h1C3A_60F5,
  parameter int unsigned BSR_LEN = 8,
  parameter int unsigned PIN_CNT = 6
) (
  input  logic               tck,
  input  logic               por_n,
  input  tap_state_t         st,
  input  dr_sel_t            sel,
  input  logic               tdi,
  input  logic [PIN_CNT-1:0] pin_sample,
  output logic               dr_so,
  output logic [PIN_CNT-1:0] ring_data
);

  localparam int unsigned ID_W = 32;

  logic               byp_q;
  logic [ID_W-1:0]    id_sr;
  logic [BSR_LEN-1:0] bsr;
  logic [BSR_LEN-1:0] cap_v;

  // pin cells take the ring sample, placeholder cells capture a constant one
  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    if (i < PIN_CNT) begin : g_pin
      assign cap_v[i] = pin_sample[i];
    end else begin : g_fill
      assign cap_v[i] = 1'b1;
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      byp_q <= 1'b0;
      id_sr <= ID_CODE;
      bsr   <= '1;
    end else if (st == S_CAP_DR) begin
      case (sel)
        SEL_BYP: byp_q <= 1'b0;
        SEL_ID:  id_sr <= ID_CODE;
        default: bsr   <= cap_v;
      endcase
    end else if (st == S_SH_DR) begin
      case (sel)
        SEL_BYP: byp_q <= tdi;
        SEL_ID:  id_sr <= {tdi, id_sr[ID_W-1:1]};
        default: bsr   <= {tdi, bsr[BSR_LEN-1:1]};
      endcase
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                               ring_data <= '0;
    else if (st == S_UPD_DR && sel == SEL_BND) ring_data <= bsr[PIN_CNT-1:0];
  end

  always_comb begin
    case (sel)
      SEL_BYP: dr_so = byp_q;
      SEL_ID:  dr_so = id_sr[0];
      default: dr_so = bsr[0];
    endcase
  end

  a_r10_ring_holds: assert property (@(posedge tck) disable iff (!por_n)
    (st != S_UPD_DR) |=> $stable(ring_data));

endmodule

// File: rtl/bscan_tap_ctrl.sv
module bscan_tap_ctrl
  import scan_pkg::*;
#(
  parameter logic [31:0] ID_CODE = 32'h1C3A_60F5,
  parameter int unsigned BSR_LEN = 8,
  parameter int unsigned PIN_CNT = 6
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [PIN_CNT-1:0] pin_sample,
  output logic               tdo,
  output logic               tdo_oe,
  output logic               force_hiz,
  output logic               ring_capture,
  output logic               ring_drive,
  output logic [PIN_CNT-1:0] ring_data
);

  tap_state_t      st;
  logic [IR_W-1:0] ir_q;
  logic            ir_so;
  logic            dr_so;
  dr_sel_t         sel;
  logic            so;

  tap_fsm u_fsm (.tck(tck), .por_n(por_n), .tms(tms), .st(st));

  tap_ir u_ir (.tck(tck), .por_n(por_n), .st(st), .tdi(tdi), .ir_q(ir_q), .ir_so(ir_so));

  assign sel = decode_sel(ir_q);

  tap_dr #(.ID_CODE(ID_CODE), .BSR_LEN(BSR_LEN), .PIN_CNT(PIN_CNT)) u_dr (
    .tck(tck), .por_n(por_n), .st(st), .sel(sel), .tdi(tdi),
    .pin_sample(pin_sample), .dr_so(dr_so), .ring_data(ring_data)
  );

  assign so = (st == S_SH_IR) ? ir_so : dr_so;

  // serial output is retimed to the falling edge
  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= so;
      tdo_oe <= (st == S_SH_DR) || (st == S_SH_IR);
    end
  end

  assign force_hiz    = (ir_q == OP_SAMPZ);
  assign ring_drive   = (ir_q == OP_EXT);
  assign ring_capture = (st == S_CAP_DR) && (sel == SEL_BND);

  a_r8_oe_in_shift: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe |-> (st == S_SH_DR || st == S_SH_IR));

  a_r11_hiz_after_update: assert property (@(posedge tck) disable iff (!por_n)
    $rose(force_hiz) |-> ($past(st) == S_UPD_IR));

endmodule

// File: tb/sim_bscan_tap_ctrl.sv
`timescale 1ns/1ps
module sim_bscan_tap_ctrl;

  localparam logic [31:0] IDC = 32'h1C3A_60F5;
  localparam int BL = 8;
  localparam int PC = 6;

  logic          tck = 1'b0;
  logic          por_n = 1'b0;
  logic          tms = 1'b1;
  logic          tdi = 1'b1;
  logic [PC-1:0] pin_sample = '0;
  logic          tdo, tdo_oe, force_hiz, ring_capture, ring_drive;
  logic [PC-1:0] ring_data;

  int n_chk = 0;
  int n_bad = 0;
  int cap_cnt = 0;

  logic  exp_b[$];
  string exp_t[$];

  always #4 tck = ~tck;

  bscan_tap_ctrl #(.ID_CODE(IDC), .BSR_LEN(BL), .PIN_CNT(PC)) u0 (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .pin_sample(pin_sample),
    .tdo(tdo), .tdo_oe(tdo_oe), .force_hiz(force_hiz), .ring_capture(ring_capture),
    .ring_drive(ring_drive), .ring_data(ring_data)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: serial bits appear after the falling edge; pop and compare
  initial begin
    forever begin
      @(negedge tck);
      #2;
      if (ring_capture) cap_cnt++;
      if (exp_b.size() > 0) begin
        logic  e;
        string t;
        e = exp_b.pop_front();
        t = exp_t.pop_front();
        check(tdo_oe === 1'b1 && tdo === e, t, {62'd0, tdo_oe, tdo}, {62'd0, 1'b1, e});
      end
    end
  end

  // driver: one controller step, optionally announcing the expected serial bit
  task automatic step(input logic m, input logic d, input bit has_e, input logic e, input string tag);
    @(negedge tck);
    #1;
    tms = m;
    tdi = d;
    if (has_e) begin
      exp_b.push_back(e);
      exp_t.push_back(tag);
    end
    @(posedge tck);
  endtask

  // from idle: load an instruction; optionally check force_hiz before update (R3)
  task automatic load_ir(input logic [2:0] code, input bit chk_early, input logic hiz_before);
    logic [2:0] capv;
    capv = 3'b001;
    step(1, 0, 0, 0, "");
    step(1, 0, 0, 0, "");
    step(0, 0, 0, 0, "");
    step(0, 0, 0, 0, "");
    for (int i = 0; i < 3; i++) step(i == 2, code[i], 1, capv[i], "R5 capture-instruction bit");
    #1;
    if (chk_early) check(force_hiz === hiz_before, "R3 instruction not yet active", force_hiz, hiz_before);
    step(1, 0, 0, 0, "");
    step(0, 0, 0, 0, "");
    #1;
  endtask

  // from idle: data scan of n bits
  task automatic shift_dr(input int n, input logic [63:0] vin, input logic [63:0] vexp, input string tag);
    step(1, 0, 0, 0, "");
    step(0, 0, 0, 0, "");
    step(0, 0, 0, 0, "");
    for (int i = 0; i < n; i++) step(i == n - 1, vin[i], 1, vexp[i], tag);
    step(1, 0, 0, 0, "");
    step(0, 0, 0, 0, "");
    #1;
  endtask

  task automatic drain();
    repeat (3) @(negedge tck);
    #3;
  endtask

  initial begin
    repeat (3) @(posedge tck);
    #1;
    check(tdo_oe === 1'b0 && force_hiz === 1'b0 && ring_data === '0, "R1 reset state",
          {tdo_oe, force_hiz, ring_data}, 0);
    @(negedge tck);
    #1 por_n = 1'b1;
    step(0, 0, 0, 0, "");
    // R4 / R2: identification word out LSB first with no instruction loaded
    shift_dr(32, 64'h0, {32'd0, IDC}, "R2/R4 idcode after power-up");
    drain();
    check(tdo_oe === 1'b0, "R8 oe low in idle", tdo_oe, 0);

    // R6 bypass
    load_ir(3'b111, 0, 0);
    shift_dr(8, 64'hCB, 64'h96, "R6 bypass delay");
    // R7 aliases
    load_ir(3'b011, 0, 0);
    shift_dr(8, 64'hCB, 64'h96, "R7 code 011 as bypass");
    load_ir(3'b101, 0, 0);
    shift_dr(8, 64'hCB, 64'h96, "R7 code 101 as bypass");
    load_ir(3'b110, 0, 0);
    shift_dr(8, 64'hCB, 64'h96, "R7 code 110 as bypass");
    drain();

    // R9/R10 sample-preload
    pin_sample = 6'b101101;
    load_ir(3'b100, 0, 0);
    check(force_hiz === 1'b0 && ring_drive === 1'b0, "R11 no force under 100", {force_hiz, ring_drive}, 0);
    cap_cnt = 0;
    shift_dr(8, 64'hA5, 64'hED, "R9 pins and filler ones");
    drain();
    check(cap_cnt == 1, "R9 one capture strobe", cap_cnt, 1);
    check(ring_data === 6'h25, "R10 update stage", ring_data, 6'h25);

    // R3 and R11: sample with high-Z force
    pin_sample = 6'b010011;
    load_ir(3'b010, 1, 1'b0);
    check(force_hiz === 1'b1, "R11 force after update", force_hiz, 1);
    shift_dr(8, 64'h3C, 64'hD3, "R9 capture under 010");
    drain();
    check(ring_data === 6'h3C, "R10 update under 010", ring_data, 6'h3C);
    check(force_hiz === 1'b1, "R11 force held while 010 current", force_hiz, 1);

    // R10 external test drives pins; R11 force drops
    load_ir(3'b000, 1, 1'b1);
    check(ring_drive === 1'b1 && force_hiz === 1'b0, "R10 drive under 000", {ring_drive, force_hiz}, 2'b10);

    // R1: five ones from the middle of a bypass scan
    load_ir(3'b111, 0, 0);
    step(1, 0, 0, 0, "");
    step(0, 0, 0, 0, "");
    step(0, 0, 0, 0, "");
    step(0, 1, 1, 0, "R6 first bypass bit");
    repeat (5) step(1, 1, 0, 0, "");
    #1;
    check(ring_drive === 1'b0 && force_hiz === 1'b0, "R1 reset restores idcode", {ring_drive, force_hiz}, 0);
    step(0, 0, 0, 0, "");
    shift_dr(32, 64'hFFFF, {32'd0, IDC}, "R1/R4 idcode after five ones");
    drain();
    check(ring_data === 6'h3C, "R10 ring holds outside update", ring_data, 6'h3C);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge tck);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule